// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Word

This block holds an 8-bit accumulator, a helper register B and a program status word. It carries out five arithmetic operations: add, add with carry, subtract with borrow, multiply and divide. When an operation is applied, the block updates the carry, half-carry and overflow flags in the status word. Add and subtract take their second value from an operand input. Multiply and divide use B as the second value and write their results back into the accumulator and B.

Software reaches the three registers as whole bytes through a special-function-register port. A write takes effect on the next clock edge. The read data is combinational from the address. Two of the status bits select one of four 8-byte register banks, and the block drives the base address of the selected bank to the register file next to it. The parity bit is not stored. It is derived at all times from the accumulator.

The asynchronous active-low reset is released synchronously, two clock edges after the reset pin goes high.

Top module: `alu_psw_core`

## Requirements
- R1: After reset the accumulator, B and the status word all read 0x00, and the bank base output is 0.
- R2: With op_valid high, op_sel 0 (add) or op_sel 1 (add with carry) loads the accumulator with accumulator + operand, plus the current carry flag for op_sel 1. The carry flag takes the carry out of bit 7. The half-carry flag takes the carry from bit 3 into bit 4. The overflow flag is set when the signed two's-complement result falls outside -128..127.
- R3: op_sel 2 (subtract with borrow) loads the accumulator with accumulator - operand - carry. The carry flag is set when the result needs a borrow. The half-carry flag is set when the low nibble needs a borrow. The overflow flag is set when the signed result falls outside -128..127.
- R4: op_sel 3 (multiply) forms accumulator × B. The low byte goes to the accumulator and the high byte to B. The carry and half-carry flags are cleared. The overflow flag is set exactly when the product exceeds 255.
- R5: op_sel 4 (divide) writes accumulator / B to the accumulator and the remainder to B, and clears carry, half-carry and overflow. When B is zero, the overflow flag is set, carry and half-carry are cleared, and the values of the accumulator and B are unspecified.
- R6: Status bit 0 always equals the XOR of the eight accumulator bits. A write to that bit has no effect.
- R7: The status word has this layout: bit 7 carry, bit 6 half-carry, bit 5 user flag A, bits 4:3 bank select, bit 2 overflow, bit 1 user flag B, bit 0 parity. The register addresses are: status word 0xD0, accumulator 0xE0, B 0xF0. A write to one of these addresses stores sfr_wdata on the next edge. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R8: bank_base equals the bank-select field × 8, so the values are 0x00, 0x08, 0x10 and 0x18.
- R9: Arithmetic operations never change the two user flags or the bank-select field.
- R10: When a status-word write and an operation fall in the same cycle, the operation sets carry, half-carry and overflow, and the write sets the user flags and bank select. When an accumulator or B write meets an operation that writes the same register, the operation's result is stored.
- R11: With op_valid low, or with op_sel 5 to 7, no register changes apart from what an SFR write stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply op_sel on this edge |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract with borrow, 3 multiply, 4 divide) |
| operand | input | 8 | Second value for add and subtract |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Read data for sfr_addr, combinational |
| acc_o | output | 8 | Accumulator value |
| b_o | output | 8 | B register value |
| psw_o | output | 8 | Status word including live parity |
| bank_base | output | 5 | Base address of the selected register bank |

## Verification
The add and subtract paths are driven with operand pairs chosen to tell the flags apart: a pair that carries only out of the low nibble, one that overflows in signed terms without an unsigned carry, one that does both, and one where a carry-in alone causes the borrow. Multiply is run with products just above and well below 256, so that an overflow flag tied to the wrong product byte is exposed. Divide is run with a non-zero divisor and with a zero divisor. Same-cycle status writes and idle or unused op codes separate the write-versus-operation priority from plain register storage, and a long run of random mixed traffic is then checked against the bench model on every clock.

// File: rtl/alu_psw_pkg.sv
package alu_psw_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUBB = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4
  } alu_op_e;

  // stored part of the status word; parity is derived, not kept
  typedef struct packed {
    logic       cy;
    logic       ac;
    logic       uf_a;
    logic [1:0] bank;
    logic       ov;
    logic       uf_b;
  } psw_store_t;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic         [W-1:0] a,
  input  logic         [W-1:0] b,
  input  logic                 cin,
  input  logic                 sub,
  output logic         [W-1:0] res,
  output logic                 cy,
  output logic                 ac,
  output logic                 ov
);
  localparam int NW = 4;

  logic [W:0]  full;
  logic [NW:0] half;
  logic [W:0]  cin_w;
  logic [NW:0] cin_n;

  always_comb begin
    cin_w = {{W{1'b0}}, cin};
    cin_n = {{NW{1'b0}}, cin};
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - cin_w;
      half = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - cin_n;
    end else begin
      full = {1'b0, a} + {1'b0, b} + cin_w;
      half = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + cin_n;
    end
    res = full[W-1:0];
    cy  = full[W];
    ac  = half[NW];
    if (sub) ov = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
    else     ov = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic         mul_big,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         div_zero
);
  logic [2*W-1:0] prod;
  logic [W-1:0]   divisor;
  logic [W:0]     part;

  always_comb begin
    prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    prod_lo  = prod[W-1:0];
    prod_hi  = prod[2*W-1:W];
    mul_big  = |prod_hi;
    div_zero = (b == '0);
    divisor  = div_zero ? {{(W-1){1'b0}}, 1'b1} : b;
    // restoring division, one quotient bit per step
    part = '0;
    quot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {part[W-1:0], a[i]};
      if (part >= {1'b0, divisor}) begin
        part    = part - {1'b0, divisor};
        quot[i] = 1'b1;
      end
    end
    rem = part[W-1:0];
  end
endmodule

// File: rtl/alu_psw_core.sv
module alu_psw_core #(
  parameter int          DATA_W        = 8,
  parameter logic [7:0]  PSW_ADDR      = 8'hD0,
  parameter logic [7:0]  ACC_ADDR      = 8'hE0,
  parameter logic [7:0]  B_ADDR        = 8'hF0,
  parameter int          BANK_BYTES_LG = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [2:0]                   op_sel,
  input  logic [DATA_W-1:0]            operand,
  input  logic                         sfr_wr,
  input  logic [7:0]                   sfr_addr,
  input  logic [DATA_W-1:0]            sfr_wdata,
  output logic [DATA_W-1:0]            sfr_rdata,
  output logic [DATA_W-1:0]            acc_o,
  output logic [DATA_W-1:0]            b_o,
  output logic [7:0]                   psw_o,
  output logic [BANK_BYTES_LG+1:0]     bank_base
);
  import alu_psw_pkg::*;

  localparam int BASE_W = BANK_BYTES_LG + 2;

  logic rst_q_n;
  logic [DATA_W-1:0] acc_q, acc_d, b_q, b_d;
  psw_store_t psw_q, psw_d;
  logic acc_en, b_en, psw_en;

  logic [DATA_W-1:0] as_res, md_lo, md_hi, md_quot, md_rem;
  logic as_cy, as_ac, as_ov, md_big, md_dz;
  logic is_sub, cin;

  alu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign is_sub = (op_sel == OP_SUBB);
  assign cin    = (op_sel == OP_ADD) ? 1'b0 : psw_q.cy;

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a(acc_q), .b(operand), .cin(cin), .sub(is_sub),
    .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  alu_muldiv #(.W(DATA_W)) u_muldiv (
    .a(acc_q), .b(b_q),
    .prod_lo(md_lo), .prod_hi(md_hi), .mul_big(md_big),
    .quot(md_quot), .rem(md_rem), .div_zero(md_dz)
  );

  // next-state: SFR write first, ALU result overrides where both land
  always_comb begin
    acc_d  = acc_q;
    b_d    = b_q;
    psw_d  = psw_q;
    acc_en = 1'b0;
    b_en   = 1'b0;
    psw_en = 1'b0;
    if (sfr_wr) begin
      unique case (sfr_addr)
        ACC_ADDR: begin acc_d = sfr_wdata; acc_en = 1'b1; end
        B_ADDR:   begin b_d = sfr_wdata;   b_en = 1'b1;   end
        PSW_ADDR: begin
          psw_d  = {sfr_wdata[7:1]};
          psw_en = 1'b1;
        end
        default: ;
      endcase
    end
    if (op_valid) begin
      unique case (op_sel)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_d = as_res; acc_en = 1'b1;
          psw_d.cy = as_cy; psw_d.ac = as_ac; psw_d.ov = as_ov;
          psw_en = 1'b1;
        end
        OP_MUL: begin
          acc_d = md_lo; b_d = md_hi; acc_en = 1'b1; b_en = 1'b1;
          psw_d.cy = 1'b0; psw_d.ac = 1'b0; psw_d.ov = md_big;
          psw_en = 1'b1;
        end
        OP_DIV: begin
          if (!md_dz) begin
            acc_d = md_quot; b_d = md_rem; acc_en = 1'b1; b_en = 1'b1;
          end
          psw_d.cy = 1'b0; psw_d.ac = 1'b0; psw_d.ov = md_dz;
          psw_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      b_q   <= '0;
      psw_q <= '0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (b_en)   b_q   <= b_d;
      if (psw_en) psw_q <= psw_d;
    end
  end

  assign acc_o     = acc_q;
  assign b_o       = b_q;
  assign psw_o     = {psw_q, ^acc_q};
  assign bank_base = BASE_W'({psw_q.bank, {BANK_BYTES_LG{1'b0}}});

  always_comb begin
    unique case (sfr_addr)
      ACC_ADDR: sfr_rdata = acc_q;
      B_ADDR:   sfr_rdata = b_q;
      PSW_ADDR: sfr_rdata = psw_o;
      default:  sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/alu_psw_chk.sv
module alu_psw_chk #(
  parameter logic [7:0] PSW_ADDR = 8'hD0,
  parameter logic [7:0] ACC_ADDR = 8'hE0,
  parameter logic [7:0] B_ADDR   = 8'hF0
) (
  input logic       clk,
  input logic       rst_q_n,
  input logic       op_valid,
  input logic [2:0] op_sel,
  input logic [7:0] operand,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_rdata,
  input logic [7:0] acc_o,
  input logic [7:0] b_o,
  input logic [7:0] psw_o
);
  logic [8:0]  add9;
  logic [15:0] mul16;
  logic        psw_hit;

  assign add9    = {1'b0, acc_o} + {1'b0, operand};
  assign mul16   = {8'h00, acc_o} * {8'h00, b_o};
  assign psw_hit = sfr_wr && (sfr_addr == PSW_ADDR);

  // R2
  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && op_sel == 3'd0) |=> (psw_o[7] == $past(add9[8])));

  // R4
  a_r4_mul_ovf: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && op_sel == 3'd3) |=> (psw_o[2] == $past(mul16 > 16'd255)) && !psw_o[7]);

  // R5
  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && op_sel == 3'd4 && b_o == 8'h00) |=> psw_o[2] && !psw_o[7] && !psw_o[6]);

  // R6
  a_r6_parity_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sfr_addr == PSW_ADDR) |-> (sfr_rdata[0] == ^acc_o));

  // R7
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sfr_addr != PSW_ADDR && sfr_addr != ACC_ADDR && sfr_addr != B_ADDR) |-> (sfr_rdata == 8'h00));

  // R9
  a_r9_user_kept: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && !psw_hit) |=> $stable({psw_o[5:3], psw_o[1]}));

  // R11
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!op_valid && !sfr_wr) |=> $stable(acc_o) && $stable(b_o) && $stable(psw_o));
endmodule

bind alu_psw_core alu_psw_chk #(
  .PSW_ADDR(PSW_ADDR), .ACC_ADDR(ACC_ADDR), .B_ADDR(B_ADDR)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .op_valid(op_valid), .op_sel(op_sel),
  .operand(operand), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .sfr_rdata(sfr_rdata), .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o)
);

// File: tb/sim_alu_psw_core.sv
`timescale 1ns/1ps
module sim_alu_psw_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] operand = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata, acc_o, b_o, psw_o;
  logic [4:0] bank_base;

  localparam logic [7:0] A_PSW = 8'hD0, A_ACC = 8'hE0, A_B = 8'hF0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  int m_acc = 0, m_b = 0, m_rs = 0;
  bit m_cy = 0, m_ac = 0, m_f0 = 0, m_ov = 0, m_f1 = 0;
  bit acc_unk = 0, b_unk = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  alu_psw_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .acc_o(acc_o),
    .b_o(b_o), .psw_o(psw_o), .bank_base(bank_base)
  );

  function automatic bit par8(int v);
    bit p = 0;
    for (int i = 0; i < 8; i++) p ^= v[i];
    return p;
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int exp_hi7();
    return (m_cy << 6) | (m_ac << 5) | (m_f0 << 4) | (m_rs << 2) | (m_ov << 1) | m_f1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!acc_unk) chk(cur_tag, "acc", acc_o, m_acc);
    if (!b_unk)   chk(cur_tag, "b", b_o, m_b);
    chk(cur_tag, "psw[7:1]", psw_o[7:1], exp_hi7());
    chk("R6", "parity", psw_o[0], par8(acc_o));
    chk("R8", "bank_base", bank_base, m_rs * 8);
    case (sfr_addr)
      A_PSW: chk("R7", "rd psw[7:1]", sfr_rdata[7:1], exp_hi7());
      A_ACC: if (!acc_unk) chk("R7", "rd acc", sfr_rdata, m_acc);
      A_B:   if (!b_unk) chk("R7", "rd b", sfr_rdata, m_b);
      default: chk("R7", "rd unmapped", sfr_rdata, 0);
    endcase
  endtask

  task automatic model(bit v, int op, int opnd, bit wr, int addr, int wd);
    int oa = m_acc, ob = m_b, s, ss, cin;
    bit ocy = m_cy;
    if (wr) begin
      if (addr == A_PSW) begin
        m_cy = wd[7]; m_ac = wd[6]; m_f0 = wd[5]; m_rs = (wd >> 3) & 3;
        m_ov = wd[2]; m_f1 = wd[1];
      end else if (addr == A_ACC) begin
        m_acc = wd; acc_unk = 0;
      end else if (addr == A_B) begin
        m_b = wd; b_unk = 0;
      end
    end
    if (v) begin
      case (op)
        0, 1: begin
          cin = (op == 1) ? int'(ocy) : 0;
          s = oa + opnd + cin;
          m_acc = s & 255; m_cy = (s > 255);
          m_ac = ((oa & 15) + (opnd & 15) + cin) > 15;
          ss = sgn(oa) + sgn(opnd) + cin;
          m_ov = (ss > 127) || (ss < -128);
        end
        2: begin
          s = oa - opnd - int'(ocy);
          m_acc = s & 255; m_cy = (s < 0);
          m_ac = ((oa & 15) - (opnd & 15) - int'(ocy)) < 0;
          ss = sgn(oa) - sgn(opnd) - int'(ocy);
          m_ov = (ss > 127) || (ss < -128);
        end
        3: begin
          s = oa * ob;
          m_acc = s & 255; m_b = s >> 8;
          m_cy = 0; m_ac = 0; m_ov = (s > 255);
        end
        4: begin
          m_cy = 0; m_ac = 0;
          if (ob == 0) begin
            m_ov = 1; acc_unk = 1; b_unk = 1;
          end else begin
            m_acc = oa / ob; m_b = oa % ob; m_ov = 0;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(bit v, int op, int opnd, bit wr, int addr, int wd, string tag);
    @(negedge clk);
    compare();
    op_valid = v; op_sel = op[2:0]; operand = opnd[7:0];
    sfr_wr = wr; sfr_addr = addr[7:0]; sfr_wdata = wd[7:0];
    if (rst_n) model(v, op, opnd, wr, addr, wd);
    cur_tag = tag;
  endtask

  task automatic wr_reg(int addr, int wd, string tag);
    step(0, 0, 0, 1, addr, wd, tag);
  endtask

  task automatic op_do(int op, int opnd, string tag);
    step(1, op, opnd, 0, 8'h00, 0, tag);
  endtask

  function automatic string op_tag(int op);
    case (op)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1'b1;
    // R1: idle through reset release and synchroniser
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, A_PSW, 0, "R1");

    // R7: register writes, unmapped read and write
    wr_reg(A_ACC, 8'h7F, "R7");
    wr_reg(A_B, 8'h03, "R7");
    step(0, 0, 0, 0, 8'h55, 0, "R7");
    wr_reg(8'h55, 8'hAA, "R7");
    step(0, 0, 0, 0, A_B, 0, "R7");

    // R2: add flag patterns
    op_do(0, 8'h01, "R2");        // 0x80: AC, OV
    op_do(0, 8'h80, "R2");        // 0x00: CY, OV
    op_do(1, 8'h0F, "R2");        // with carry: 0x10, AC
    wr_reg(A_ACC, 8'hFF, "R2");
    op_do(0, 8'h01, "R2");        // 0x00: CY, AC
    op_do(1, 8'h00, "R2");        // carry-in only

    // R6: parity write ignored
    wr_reg(A_PSW, 8'h01, "R6");
    wr_reg(A_ACC, 8'h07, "R6");
    step(0, 0, 0, 0, A_PSW, 0, "R6");

    // R3: subtract with borrow
    wr_reg(A_ACC, 8'h00, "R3");
    wr_reg(A_PSW, 8'h00, "R3");
    op_do(2, 8'h01, "R3");        // 0xFF CY AC
    op_do(2, 8'h00, "R3");        // borrow in: 0xFE
    wr_reg(A_ACC, 8'h80, "R3");
    op_do(2, 8'h01, "R3");        // 0x7F OV AC
    wr_reg(A_ACC, 8'h10, "R3");
    op_do(2, 8'h01, "R3");        // 0x0F AC

    // R4: multiply
    wr_reg(A_ACC, 8'h10, "R4");
    wr_reg(A_B, 8'h10, "R4");
    op_do(3, 0, "R4");            // 0x0100 OV
    wr_reg(A_ACC, 8'h0F, "R4");
    wr_reg(A_B, 8'h03, "R4");
    op_do(3, 0, "R4");            // 0x002D

    // R5: divide and divide-by-zero
    wr_reg(A_ACC, 8'hFB, "R5");
    wr_reg(A_B, 8'h12, "R5");
    op_do(4, 0, "R5");            // q=0x0D r=0x11
    wr_reg(A_B, 8'h00, "R5");
    op_do(4, 0, "R5");            // OV set
    wr_reg(A_ACC, 8'h33, "R5");
    wr_reg(A_B, 8'h44, "R5");

    // R8: every bank
    for (int k = 0; k < 4; k++) wr_reg(A_PSW, k * 8, "R8");

    // R9: user flags and bank survive operations
    wr_reg(A_PSW, 8'h3A, "R9");
    op_do(0, 8'h01, "R9");
    op_do(2, 8'h05, "R9");
    op_do(3, 0, "R9");
    op_do(4, 0, "R9");
    wr_reg(A_ACC, 8'h21, "R9");
    wr_reg(A_B, 8'h05, "R9");

    // R10: same-cycle write and operation
    step(1, 0, 8'h01, 1, A_PSW, 8'hDC, "R10");
    step(1, 2, 8'h01, 1, A_ACC, 8'h99, "R10");
    step(1, 3, 0, 1, A_B, 8'h77, "R10");
    step(1, 0, 8'h02, 1, A_B, 8'h66, "R10");

    // R11: idle and unused codes
    step(0, 0, 8'h11, 0, A_ACC, 0, "R11");
    for (int c = 5; c < 8; c++) op_do(c, 8'hA5, "R11");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      if (acc_unk || b_unk) begin
        wr_reg(A_ACC, $urandom_range(0, 255), "R7");
        wr_reg(A_B, $urandom_range(0, 255), "R7");
      end else begin
        int op = $urandom_range(0, 7);
        int ad;
        bit v = ($urandom_range(0, 3) != 0);
        bit w = ($urandom_range(0, 3) == 0);
        case ($urandom_range(0, 3))
          0: ad = A_PSW; 1: ad = A_ACC; 2: ad = A_B; default: ad = 8'h5A;
        endcase
        if (op == 4 && $urandom_range(0, 1) == 0 && !(w && ad == A_B)) begin
          step(0, 0, 0, 1, A_B, $urandom_range(1, 255), "R5");
        end
        step(v, op, $urandom_range(0, 255), w, ad, $urandom_range(0, 255),
             (v && w) ? "R10" : (v ? op_tag(op) : "R7"));
      end
    end
    step(0, 0, 0, 0, A_PSW, 0, "R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule